// File: doc/BRIEF.md
# Local Bus Transaction Engine

This block executes the bus commands carried in a control packet. Its input is the payload of a packet that has already been received, delivered one byte per handshake with markers on the first and final byte. The block breaks the payload into 32-bit words and reads one command after another: READ, WRITE or read-modify-write. It runs each command as strobe/acknowledge cycles on an internal parallel bus, and it returns the results as a reply byte stream that carries the same kind of markers.

Each bus word is a separate cycle. The block holds the strobe until the slave acknowledges or signals an error. It also keeps an internal watchdog, so a silent slave cannot hang the block. Each command ends with a status word. This word is the command's header with a status code written into it. Software on the far side can then match every reply word to what it requested.

Top module: `lbus_txn_engine`

## Requirements
- R1: A command header is one big-endian word. Bits [31:28] are the kind (1 = READ, 2 = WRITE, 3 = read-modify-write) and bits [15:0] are the word count. Any other kind gives status 3 with no bus cycle, and the rest of that packet is discarded.
- R2: A READ with count N runs N read cycles at addresses A, A+1, and so on. It replies with the N read words in address order, followed by its status word.
- R3: A WRITE with count N consumes N data words after the address word. It runs N write cycles at A, A+1, and so on, each carrying its own data word.
- R4: A read-modify-write reads A once and then writes (old AND mask) OR set back to A. The mask is the word after the address and the set value is the word after the mask. The reply is the old value followed by the status word.
- R5: Commands run and reply strictly in packet order. The status word equals the header with bits [27:24] replaced by the status code (0 = OK). The first reply byte of a packet carries the start marker, and the last byte of its final status word carries the end marker.
- R6: The strobe stays high, with address, data and direction held, until an acknowledge, an error or the timeout. It is low in the cycle after an acknowledge.
- R7: If the strobe has been high for 255 clocks with neither acknowledge nor error, the cycle ends. The command then reports status 2.
- R8: A bus error ends the command with status 1. Its remaining words are skipped: the remaining WRITE data words are consumed without any bus cycle, and no further read cycles are issued. Processing continues with the next command of the packet.
- R9: A READ or WRITE with count 0 issues no bus cycle and replies with status 0.
- R10: Reply words are sent most significant byte first. While out_ready is low, the output byte and its markers hold.
- R11: During and after reset, in_ready is high while out_valid and bus_strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Payload byte present |
| in_data | input | 8 | Payload byte |
| in_first | input | 1 | Byte is the first of a packet |
| in_last | input | 1 | Byte is the last of a packet |
| in_ready | output | 1 | Engine accepts the byte this cycle |
| out_valid | output | 1 | Reply byte present |
| out_data | output | 8 | Reply byte |
| out_first | output | 1 | First byte of a reply packet |
| out_last | output | 1 | Last byte of a reply packet |
| out_ready | input | 1 | Receiver takes the reply byte |
| bus_addr | output | 32 | Word address |
| bus_wdata | output | 32 | Write data |
| bus_strobe | output | 1 | Cycle in progress |
| bus_write | output | 1 | Cycle direction, 1 = write |
| bus_rdata | input | 32 | Read data from slave |
| bus_ack | input | 1 | Slave completed the cycle |
| bus_err | input | 1 | Slave rejected the cycle |

## Verification
The bench targets an error in the middle of a multiword WRITE. If the design fails to consume the leftover data words, it misreads them as headers and sends garbled replies for every later command. If it keeps issuing cycles after the error, extra writes appear in the slave log. A slave that never answers must end after exactly 255 strobe clocks with status 2; an off-by-one counter shows up as a run of 254 or 256. The read-modify-write table checks that the written value combines the old contents with both constants and that the reply carries the old value rather than the new one. Zero-count commands and an unknown kind check that no stray bus cycle occurs and that the next packet still parses, while random output backpressure exposes byte-order and marker errors.

// File: rtl/lbus_pkg.sv
package lbus_pkg;
    localparam logic [3:0] CMD_RD  = 4'd1;
    localparam logic [3:0] CMD_WR  = 4'd2;
    localparam logic [3:0] CMD_RMW = 4'd3;

    localparam logic [3:0] STS_OK   = 4'd0;
    localparam logic [3:0] STS_BERR = 4'd1;
    localparam logic [3:0] STS_TMO  = 4'd2;
    localparam logic [3:0] STS_BAD  = 4'd3;

    typedef enum logic [3:0] {
        S_HDR, S_ADDR, S_WDATA, S_MASK, S_SET, S_CYC, S_DATA, S_DRAIN, S_STAT
    } eng_state_t;
endpackage

// File: rtl/lbus_word_in.sv
module lbus_word_in #(
    parameter int BYTES = 4,
    localparam int WW = 8 * BYTES,
    localparam int CW = $clog2(BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_first,
    input  logic          in_last,
    output logic          in_ready,
    output logic          w_valid,
    output logic [WW-1:0] w_data,
    output logic          w_last,
    input  logic          w_take
);
    typedef struct packed {
        logic [WW-1:0] word;
        logic [CW-1:0] cnt;
        logic          full;
        logic          last;
    } win_t;

    win_t r_q, r_d;
    logic [CW-1:0] nxt_cnt;

    assign in_ready = !r_q.full || w_take;
    assign w_valid  = r_q.full;
    assign w_data   = r_q.word;
    assign w_last   = r_q.last;

    always_comb begin
        r_d     = r_q;
        nxt_cnt = (in_first ? '0 : r_q.cnt) + 1'b1;
        if (w_take) r_d.full = 1'b0;
        if (in_valid && in_ready) begin
            r_d.word = {r_q.word[WW-9:0], in_data};
            if (nxt_cnt == CW'(BYTES) || in_last) begin
                r_d.full = 1'b1;
                r_d.last = in_last;
                r_d.cnt  = '0;
            end else begin
                r_d.cnt  = nxt_cnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end
endmodule

// File: rtl/lbus_byte_out.sv
module lbus_byte_out #(
    parameter int BYTES = 4,
    localparam int WW = 8 * BYTES,
    localparam int CW = $clog2(BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [WW-1:0] ld_word,
    input  logic          ld_first,
    input  logic          ld_last,
    output logic          free,
    output logic          out_valid,
    output logic [7:0]    out_data,
    output logic          out_first,
    output logic          out_last,
    input  logic          out_ready
);
    typedef struct packed {
        logic [WW-1:0] sh;
        logic [CW-1:0] left;
        logic          first;
        logic          last;
    } bout_t;

    bout_t r_q, r_d;

    assign out_valid = (r_q.left != '0);
    assign out_data  = r_q.sh[WW-1 -: 8];
    assign out_first = r_q.first && (r_q.left == CW'(BYTES));
    assign out_last  = r_q.last && (r_q.left == CW'(1));
    assign free      = (r_q.left == '0) || ((r_q.left == CW'(1)) && out_ready);

    always_comb begin
        r_d = r_q;
        if (ld) begin
            r_d.sh    = ld_word;
            r_d.left  = CW'(BYTES);
            r_d.first = ld_first;
            r_d.last  = ld_last;
        end else if (out_valid && out_ready) begin
            r_d.sh    = {r_q.sh[WW-9:0], 8'h00};
            r_d.left  = r_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end
endmodule

// File: rtl/lbus_txn_engine.sv
module lbus_txn_engine
    import lbus_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CNT_W = 16,
    parameter int TMO_CYCLES = 255,
    localparam int BYTES = DW / 8,
    localparam int TW = $clog2(TMO_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_first,
    input  logic          in_last,
    output logic          in_ready,
    output logic          out_valid,
    output logic [7:0]    out_data,
    output logic          out_first,
    output logic          out_last,
    input  logic          out_ready,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_strobe,
    output logic          bus_write,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    input  logic          bus_err
);
    typedef struct packed {
        eng_state_t       st;
        logic [DW-1:0]    hdr;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic [DW-1:0]    mask;
        logic [DW-1:0]    setv;
        logic [DW-1:0]    rword;
        logic [CNT_W-1:0] rem;
        logic [TW-1:0]    tmo;
        logic [3:0]       stat;
        logic             pend_last;
        logic             to_last;
        logic             strobe;
        logic             wr;
        logic             first;
    } eng_t;

    eng_t r_q, r_d;

    logic          w_valid, w_last, w_take;
    logic [DW-1:0] w_data;
    logic          ld, ld_first, ld_last, ser_free;
    logic [DW-1:0] ld_word;
    logic [3:0]    kind, w_kind;
    logic [CNT_W-1:0] cnt;
    logic          tmo_hit;

    lbus_word_in #(.BYTES(BYTES)) u_win (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_first(in_first), .in_last(in_last), .in_ready(in_ready),
        .w_valid(w_valid), .w_data(w_data), .w_last(w_last), .w_take(w_take)
    );

    lbus_byte_out #(.BYTES(BYTES)) u_bout (
        .clk(clk), .rst(rst), .ld(ld), .ld_word(ld_word), .ld_first(ld_first),
        .ld_last(ld_last), .free(ser_free), .out_valid(out_valid),
        .out_data(out_data), .out_first(out_first), .out_last(out_last),
        .out_ready(out_ready)
    );

    assign kind       = r_q.hdr[DW-1 -: 4];
    assign w_kind     = w_data[DW-1 -: 4];
    assign cnt        = r_q.hdr[CNT_W-1:0];
    assign tmo_hit    = (r_q.tmo == TW'(TMO_CYCLES - 1));
    assign bus_addr   = r_q.addr;
    assign bus_wdata  = r_q.wdata;
    assign bus_strobe = r_q.strobe;
    assign bus_write  = r_q.wr;

    always_comb begin
        r_d      = r_q;
        w_take   = 1'b0;
        ld       = 1'b0;
        ld_word  = '0;
        ld_first = 1'b0;
        ld_last  = 1'b0;
        unique case (r_q.st)
            S_HDR: if (w_valid) begin
                w_take      = 1'b1;
                r_d.hdr     = w_data;
                r_d.pend_last = w_last;
                r_d.stat    = STS_OK;
                r_d.st      = S_ADDR;
                if (!(w_kind == CMD_RD || w_kind == CMD_WR || w_kind == CMD_RMW) || w_last) begin
                    r_d.stat    = STS_BAD;
                    r_d.to_last = 1'b1;
                    r_d.st      = w_last ? S_STAT : S_DRAIN;
                end
            end
            S_ADDR: if (w_valid) begin
                w_take        = 1'b1;
                r_d.addr      = w_data[AW-1:0];
                r_d.pend_last = w_last;
                r_d.rem       = (kind == CMD_RMW) ? CNT_W'(2) : cnt;
                r_d.tmo       = '0;
                if (kind == CMD_RMW)      r_d.st = S_MASK;
                else if (cnt == '0)       r_d.st = S_STAT;
                else if (kind == CMD_WR)  r_d.st = S_WDATA;
                else begin
                    r_d.st     = S_CYC;
                    r_d.strobe = 1'b1;
                    r_d.wr     = 1'b0;
                end
            end
            S_WDATA, S_MASK, S_SET: if (w_valid) begin
                w_take        = 1'b1;
                r_d.pend_last = w_last;
                r_d.tmo       = '0;
                if (r_q.st == S_MASK) begin
                    r_d.mask = w_data;
                    r_d.st   = S_SET;
                end else begin
                    if (r_q.st == S_SET) r_d.setv  = w_data;
                    else                 r_d.wdata = w_data;
                    r_d.st     = S_CYC;
                    r_d.strobe = 1'b1;
                    r_d.wr     = (r_q.st == S_WDATA);
                end
            end
            S_CYC: begin
                if (bus_err || (!bus_ack && tmo_hit)) begin
                    r_d.strobe = 1'b0;
                    r_d.wr     = 1'b0;
                    r_d.stat   = bus_err ? STS_BERR : STS_TMO;
                    r_d.st     = S_STAT;
                    if (kind == CMD_WR && r_q.rem > CNT_W'(1)) begin
                        r_d.rem     = r_q.rem - 1'b1;
                        r_d.to_last = 1'b0;
                        r_d.st      = S_DRAIN;
                    end
                end else if (bus_ack) begin
                    r_d.strobe = 1'b0;
                    r_d.wr     = 1'b0;
                    r_d.rem    = r_q.rem - 1'b1;
                    if (kind == CMD_RD) begin
                        r_d.rword = bus_rdata;
                        r_d.addr  = r_q.addr + 1'b1;
                        r_d.st    = S_DATA;
                    end else if (kind == CMD_WR) begin
                        r_d.addr  = r_q.addr + 1'b1;
                        r_d.st    = (r_q.rem == CNT_W'(1)) ? S_STAT : S_WDATA;
                    end else if (r_q.rem == CNT_W'(2)) begin
                        r_d.rword = bus_rdata;
                        r_d.wdata = (bus_rdata & r_q.mask) | r_q.setv;
                        r_d.st    = S_DATA;
                    end else begin
                        r_d.st    = S_STAT;
                    end
                end else begin
                    r_d.tmo = r_q.tmo + 1'b1;
                end
            end
            S_DATA: if (ser_free) begin
                ld        = 1'b1;
                ld_word   = r_q.rword;
                ld_first  = r_q.first;
                r_d.first = 1'b0;
                r_d.tmo   = '0;
                if (r_q.rem == '0) r_d.st = S_STAT;
                else begin
                    r_d.st     = S_CYC;
                    r_d.strobe = 1'b1;
                    r_d.wr     = (kind == CMD_RMW);
                end
            end
            S_DRAIN: if (w_valid) begin
                w_take        = 1'b1;
                r_d.pend_last = w_last;
                if (r_q.to_last) begin
                    if (w_last) r_d.st = S_STAT;
                end else begin
                    r_d.rem = r_q.rem - 1'b1;
                    if (r_q.rem == CNT_W'(1)) r_d.st = S_STAT;
                end
            end
            S_STAT: if (ser_free) begin
                ld        = 1'b1;
                ld_word   = {r_q.hdr[DW-1 -: 4], r_q.stat, r_q.hdr[DW-9:0]};
                ld_first  = r_q.first;
                ld_last   = r_q.pend_last;
                r_d.first = r_q.pend_last;
                r_d.st    = S_HDR;
            end
            default: r_d.st = S_HDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q       <= '0;
            r_q.first <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/lbus_txn_chk.sv
module lbus_txn_chk #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int TMO_CYCLES = 255,
    localparam int RW = $clog2(TMO_CYCLES + 2)
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_strobe,
    input logic          bus_write,
    input logic          bus_ack,
    input logic          bus_err,
    input logic          out_valid,
    input logic          out_ready,
    input logic [7:0]    out_data,
    input logic          out_first,
    input logic          out_last
);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)             run_q <= '0;
        else if (bus_strobe) run_q <= run_q + 1'b1;
        else                 run_q <= '0;
    end

    p_strobe_hold_r6: assert property (@(posedge clk) disable iff (rst)
        bus_strobe && !bus_ack && !bus_err && (run_q < RW'(TMO_CYCLES - 1)) |=> bus_strobe);

    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        bus_strobe && (bus_ack || bus_err) |=> !bus_strobe);

    p_bus_stable_r6: assert property (@(posedge clk) disable iff (rst)
        bus_strobe && $past(bus_strobe) |->
            $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata));

    p_tmo_bound_r7: assert property (@(posedge clk) disable iff (rst)
        bus_strobe |-> run_q < RW'(TMO_CYCLES));

    p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=>
            out_valid && $stable(out_data) && $stable(out_first) && $stable(out_last));
endmodule

bind lbus_txn_engine lbus_txn_chk #(.AW(AW), .DW(DW), .TMO_CYCLES(TMO_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_strobe(bus_strobe), .bus_write(bus_write), .bus_ack(bus_ack),
    .bus_err(bus_err), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_first(out_first), .out_last(out_last)
);

// File: tb/sim_lbus_txn_engine.sv
`timescale 1ns/1ps
module sim_lbus_txn_engine;
    localparam logic [31:0] ERR_A  = 32'h0000_0100;
    localparam logic [31:0] DEAD_A = 32'h0000_0200;
    // init, mask, set
    localparam logic [31:0] RMW_TAB [4][3] = '{
        '{32'h1234_5678, 32'hFFFF_0000, 32'h0000_00AB},
        '{32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h0000_0000},
        '{32'h0000_0000, 32'h0000_0000, 32'hDEAD_BEEF},
        '{32'hA5A5_A5A5, 32'hFFFF_FFFF, 32'h5A5A_0000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        in_valid, in_first, in_last, in_ready;
    logic [7:0]  in_data;
    logic        out_valid, out_first, out_last, out_ready;
    logic [7:0]  out_data;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_strobe, bus_write, bus_ack, bus_err;

    lbus_txn_engine u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_first(in_first), .in_last(in_last), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
        .out_last(out_last), .out_ready(out_ready), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_strobe(bus_strobe), .bus_write(bus_write),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err)
    );

    // ---------------- bus slave model ----------------
    logic [31:0] mem [16];
    int          slv_wait = 0;
    int          wc, run_q, wlog_n, run_n;
    logic [31:0] wlog_a [512];
    logic [31:0] wlog_d [512];
    int          runlog [512];

    assign bus_err   = bus_strobe && (bus_addr == ERR_A);
    assign bus_ack   = bus_strobe && (bus_addr != ERR_A) && (bus_addr != DEAD_A) && (wc >= slv_wait);
    assign bus_rdata = mem[bus_addr[3:0]];

    always @(posedge clk) begin
        if (rst) begin
            wc <= 0; run_q <= 0; wlog_n <= 0; run_n <= 0;
            for (int k = 0; k < 16; k++) mem[k] <= 32'h0;
        end else begin
            wc <= (bus_strobe && !bus_ack && !bus_err) ? wc + 1 : 0;
            if (bus_strobe) run_q <= run_q + 1;
            else if (run_q != 0) begin
                runlog[run_n] <= run_q;
                run_n <= run_n + 1;
                run_q <= 0;
            end
            if (bus_strobe && bus_write && bus_ack) begin
                mem[bus_addr[3:0]] <= bus_wdata;
                wlog_a[wlog_n] <= bus_addr;
                wlog_d[wlog_n] <= bus_wdata;
                wlog_n <= wlog_n + 1;
            end
        end
    end

    // ---------------- reply receiver ----------------
    logic [7:0]  rx_b [2048];
    logic        rx_f [2048];
    logic        rx_l [2048];
    int          rx_n = 0;
    int          bp_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    initial begin
        out_ready = 1'b0;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = (bp_mode == 0) ? 1'b1 : lfsr[0];
            if (!rst && out_valid && out_ready) begin
                rx_b[rx_n] = out_data;
                rx_f[rx_n] = out_first;
                rx_l[rx_n] = out_last;
                rx_n++;
            end
        end
    end

    // ---------------- checking infrastructure ----------------
    int          n_chk = 0, n_fail = 0;
    bit          finished = 1'b0;
    logic [31:0] tx [64];
    int          tx_n;
    logic [31:0] ex [64];
    int          ex_n;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr(input logic [3:0] k, input logic [7:0] tag, input logic [15:0] c);
        return {k, 4'h0, tag, c};
    endfunction

    function automatic logic [31:0] sts(input logic [31:0] h, input logic [3:0] s);
        return {h[31:28], s, h[23:0]};
    endfunction

    task automatic push(input logic [31:0] w);
        tx[tx_n] = w;
        tx_n++;
    endtask

    task automatic expect_w(input logic [31:0] w);
        ex[ex_n] = w;
        ex_n++;
    endtask

    task automatic clear();
        tx_n = 0;
        ex_n = 0;
    endtask

    task automatic send_pkt();
        for (int i = 0; i < tx_n; i++) begin
            for (int b = 0; b < 4; b++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_data  = tx[i][31 - 8*b -: 8];
                in_first = (i == 0) && (b == 0);
                in_last  = (i == tx_n - 1) && (b == 3);
                while (!in_ready) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
    endtask

    // send tx[], collect reply, compare against ex[]
    task automatic run_pkt(input string tag);
        int base = rx_n;
        int t = 0;
        int bad_mark = 0;
        logic [31:0] w;
        send_pkt();
        while ((rx_n - base) < ex_n * 4 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (20) @(negedge clk);
        chk(rx_n - base == ex_n * 4, {tag, " R5 reply length"}, 32'(rx_n - base), 32'(ex_n * 4));
        if (rx_n - base == ex_n * 4) begin
            for (int k = 0; k < ex_n; k++) begin
                w = {rx_b[base+4*k], rx_b[base+4*k+1], rx_b[base+4*k+2], rx_b[base+4*k+3]};
                chk(w == ex[k], {tag, " R10 reply word"}, w, ex[k]);
            end
            for (int k = 0; k < ex_n * 4; k++) begin
                if (rx_f[base+k] != (k == 0)) bad_mark++;
                if (rx_l[base+k] != (k == ex_n * 4 - 1)) bad_mark++;
            end
            chk(bad_mark == 0, {tag, " R5 packet markers"}, 32'(bad_mark), 32'd0);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] h, h2, h3;
        int rb, wb;
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_data = 8'h00;
        repeat (4) @(negedge clk);
        // R11: outputs during reset
        chk(in_ready == 1'b1 && out_valid == 1'b0 && bus_strobe == 1'b0,
            "R11 reset outputs", {29'd0, in_ready, out_valid, bus_strobe}, 32'h4);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0 && bus_strobe == 1'b0,
            "R11 after reset", {29'd0, in_ready, out_valid, bus_strobe}, 32'h4);

        // R3 multiword write, zero wait states
        slv_wait = 0; bp_mode = 0;
        clear(); rb = run_n; wb = wlog_n;
        h = hdr(4'd2, 8'h11, 16'd4);
        push(h); push(32'h4);
        for (int i = 0; i < 4; i++) push(32'hA000_0000 + i);
        expect_w(sts(h, 4'd0));
        run_pkt("R3 write4");
        chk(wlog_n - wb == 4, "R3 write cycle count", 32'(wlog_n - wb), 32'd4);
        for (int i = 0; i < 4; i++) begin
            chk(wlog_a[wb+i] == 32'(4 + i), "R3 write address", wlog_a[wb+i], 32'(4 + i));
            chk(wlog_d[wb+i] == 32'hA000_0000 + i, "R3 write data", wlog_d[wb+i], 32'hA000_0000 + i);
        end
        for (int k = rb; k < run_n; k++)
            chk(runlog[k] == 1, "R6 zero-wait strobe length", 32'(runlog[k]), 32'd1);

        // R2 multiword read, two wait states, backpressure
        slv_wait = 2; bp_mode = 1;
        clear(); rb = run_n;
        h = hdr(4'd1, 8'h22, 16'd4);
        push(h); push(32'h4);
        for (int i = 0; i < 4; i++) expect_w(32'hA000_0000 + i);
        expect_w(sts(h, 4'd0));
        run_pkt("R2 read4");
        chk(run_n - rb == 4, "R2 read cycle count", 32'(run_n - rb), 32'd4);
        for (int k = rb; k < run_n; k++)
            chk(runlog[k] == 3, "R6 strobe held through waits", 32'(runlog[k]), 32'd3);

        // R5 ordering and R9 zero count
        slv_wait = 1; bp_mode = 0;
        clear(); rb = run_n;
        h = hdr(4'd2, 8'h31, 16'd1); h2 = hdr(4'd1, 8'h32, 16'd1); h3 = hdr(4'd1, 8'h33, 16'd0);
        push(h); push(32'h9); push(32'h5A5A_1234);
        push(h2); push(32'h9);
        push(h3); push(32'h3);
        expect_w(sts(h, 4'd0)); expect_w(32'h5A5A_1234); expect_w(sts(h2, 4'd0)); expect_w(sts(h3, 4'd0));
        run_pkt("R5 multi-command");
        chk(run_n - rb == 2, "R9 zero count issues no cycle", 32'(run_n - rb), 32'd2);

        // R8 bus error inside a write, next command still runs
        slv_wait = 0;
        clear(); wb = wlog_n;
        h = hdr(4'd2, 8'h41, 16'd3); h2 = hdr(4'd1, 8'h42, 16'd1);
        push(h); push(32'hFF); push(32'hD000_0000); push(32'hD000_0001); push(32'hD000_0002);
        push(h2); push(32'h4);
        expect_w(sts(h, 4'd1)); expect_w(32'hA000_0000); expect_w(sts(h2, 4'd0));
        run_pkt("R8 write error");
        chk(wlog_n - wb == 1, "R8 writes after error", 32'(wlog_n - wb), 32'd1);
        chk(wlog_d[wb] == 32'hD000_0000, "R8 first write data", wlog_d[wb], 32'hD000_0000);

        // R8 bus error inside a read
        clear(); rb = run_n;
        h = hdr(4'd1, 8'h51, 16'd3);
        push(h); push(32'hFF);
        expect_w(32'hD000_0000); expect_w(sts(h, 4'd1));
        run_pkt("R8 read error");
        chk(run_n - rb == 2, "R8 read cycles stop", 32'(run_n - rb), 32'd2);

        // R7 timeout
        clear(); rb = run_n;
        h = hdr(4'd1, 8'h61, 16'd2);
        push(h); push(DEAD_A);
        expect_w(sts(h, 4'd2));
        run_pkt("R7 timeout");
        chk(run_n - rb == 1, "R7 single timed-out cycle", 32'(run_n - rb), 32'd1);
        chk(runlog[rb] == 255, "R7 strobe length on timeout", 32'(runlog[rb]), 32'd255);

        // R1 unknown kind discards the packet, next packet parses
        clear(); rb = run_n;
        h = hdr(4'd5, 8'h77, 16'd2);
        push(h); push(32'h1); push(32'h2);
        expect_w(sts(h, 4'd3));
        run_pkt("R1 bad kind");
        chk(run_n - rb == 0, "R1 no cycle for bad kind", 32'(run_n - rb), 32'd0);
        clear();
        h = hdr(4'd1, 8'h78, 16'd1);
        push(h); push(32'h9);
        expect_w(32'h5A5A_1234); expect_w(sts(h, 4'd0));
        run_pkt("R1 recovery");

        // R4 read-modify-write table
        bp_mode = 1; slv_wait = 1;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] nv;
            nv = (RMW_TAB[i][0] & RMW_TAB[i][1]) | RMW_TAB[i][2];
            clear(); wb = wlog_n;
            h = hdr(4'd2, 8'h80, 16'd1); h2 = hdr(4'd3, 8'h81, 16'd0); h3 = hdr(4'd1, 8'h82, 16'd1);
            push(h); push(32'(12 + i)); push(RMW_TAB[i][0]);
            push(h2); push(32'(12 + i)); push(RMW_TAB[i][1]); push(RMW_TAB[i][2]);
            push(h3); push(32'(12 + i));
            expect_w(sts(h, 4'd0)); expect_w(RMW_TAB[i][0]); expect_w(sts(h2, 4'd0));
            expect_w(nv); expect_w(sts(h3, 4'd0));
            run_pkt("R4 rmw");
            chk(wlog_n - wb == 2, "R4 write count", 32'(wlog_n - wb), 32'd2);
            chk(wlog_d[wb+1] == nv, "R4 written value", wlog_d[wb+1], nv);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule